// File: doc/BRIEF.md
# Parallel LCD Write Strobe Sequencer

This block turns one accepted request into a single write cycle on an 8080-style parallel LCD bus. A request carries a register-select bit, which tells the panel whether the word is a command or pixel/parameter data, and the data word itself. The block drives the register-select line, an active-low chip select, an active-low write strobe and the data bus. Each cycle passes through four phases in a fixed order, and each phase has its own length.

A write starts with an address phase, in which register-select and data are on the bus and chip select is still high. Chip select then falls, and after a setup phase the write strobe falls. The strobe stays low for the active phase and then rises. Chip select stays low for a hold phase before it rises. Each phase lasts its programmed count plus one clock, so a count of zero still gives one clock. The four counts are run-time inputs and are captured when a request is accepted.

Top module: `lcd_wr_seq`

## Requirements
- R1: After reset, chip select and write strobe are high, busy is low and ready is high.
- R2: After a request is accepted, register-select and data are driven for exactly cs-setup+1 clocks with chip select still high. Chip select then falls.
- R3: The write strobe falls exactly write-setup+1 clocks after chip select falls.
- R4: The write strobe stays low for exactly write-active+1 clocks.
- R5: Chip select rises exactly write-hold+1 clocks after the write strobe rises.
- R6: The four counts are captured at acceptance. Changing the count inputs during a transfer does not change the lengths of that transfer's phases.
- R7: Ready is low and busy is high from the clock after acceptance through the last hold clock. Ready is high again in the clock in which chip select returns high, so back-to-back writes each begin with a new address phase.
- R8: Register-select and data equal the accepted request and stay stable for every busy clock.
- R9: The write strobe is never low while chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Block can take a request (idle) |
| req_rs | input | 1 | Register-select bit of the request |
| req_data | input | DATA_W | Data word of the request |
| t_cs_setup | input | TIME_W | Address-to-chip-select count |
| t_wr_setup | input | TIME_W | Chip-select-to-strobe count |
| t_wr_active | input | TIME_W | Strobe-low count |
| t_wr_hold | input | TIME_W | Strobe-rise-to-chip-select-rise count |
| lcd_rs | output | 1 | Register-select line to the panel |
| lcd_cs_n | output | 1 | Active-low chip select |
| lcd_wr_n | output | 1 | Active-low write strobe |
| lcd_data | output | DATA_W | Data bus to the panel |
| busy | output | 1 | A transfer is in progress |

## Verification
The bench uses the default build: 8-bit data and 4-bit counts. With these widths it can reach both the all-zero timing, where every phase lasts one clock, and the all-fifteen timing, where every phase is at its longest. It also runs mixed counts, issues requests back to back, and changes the count inputs in the middle of a transfer. A behavioural model expands each accepted request into the expected per-clock pin values and compares the pins on every clock.

// File: rtl/lcd_wr_pkg.sv
package lcd_wr_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_ADDR = 3'd1,
    PH_CSS  = 3'd2,
    PH_ACT  = 3'd3,
    PH_HOLD = 3'd4
  } phase_e;

  // order of the bus phases; the sequence is behaviour, not layout
  function automatic phase_e phase_after(input phase_e p);
    unique case (p)
      PH_ADDR: phase_after = PH_CSS;
      PH_CSS:  phase_after = PH_ACT;
      PH_ACT:  phase_after = PH_HOLD;
      default: phase_after = PH_IDLE;
    endcase
  endfunction

  function automatic logic sel_low(input phase_e p);
    sel_low = (p == PH_CSS) || (p == PH_ACT) || (p == PH_HOLD);
  endfunction

  function automatic logic strobe_low(input phase_e p);
    strobe_low = (p == PH_ACT);
  endfunction

  // length of a phase in clocks for a programmed count
  function automatic int unsigned phase_clocks(input int unsigned count);
    phase_clocks = count + 1;
  endfunction

endpackage

// File: rtl/lcd_wr_capture.sv
module lcd_wr_capture #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned TIME_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              rs_in,
  input  logic [DATA_W-1:0] data_in,
  input  logic [TIME_W-1:0] cs_setup_in,
  input  logic [TIME_W-1:0] wr_setup_in,
  input  logic [TIME_W-1:0] wr_active_in,
  input  logic [TIME_W-1:0] wr_hold_in,
  output logic              rs_q,
  output logic [DATA_W-1:0] data_q,
  output logic [TIME_W-1:0] cs_setup_q,
  output logic [TIME_W-1:0] wr_setup_q,
  output logic [TIME_W-1:0] wr_active_q,
  output logic [TIME_W-1:0] wr_hold_q
);

  localparam logic [TIME_W-1:0] DEF_ZERO   = '0;
  localparam logic [TIME_W-1:0] DEF_ACTIVE = TIME_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q        <= 1'b0;
      data_q      <= '0;
      cs_setup_q  <= DEF_ZERO;
      wr_setup_q  <= DEF_ZERO;
      wr_active_q <= DEF_ACTIVE;
      wr_hold_q   <= DEF_ZERO;
    end else if (take) begin
      rs_q        <= rs_in;
      data_q      <= data_in;
      cs_setup_q  <= cs_setup_in;
      wr_setup_q  <= wr_setup_in;
      wr_active_q <= wr_active_in;
      wr_hold_q   <= wr_hold_in;
    end
  end

endmodule

// File: rtl/lcd_wr_phase_ctl.sv
module lcd_wr_phase_ctl
  import lcd_wr_pkg::*;
#(
  parameter int unsigned TIME_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [TIME_W-1:0] cs_setup_now,
  input  logic [TIME_W-1:0] wr_setup_q,
  input  logic [TIME_W-1:0] wr_active_q,
  input  logic [TIME_W-1:0] wr_hold_q,
  output phase_e            phase,
  output logic              phase_end
);

  logic [TIME_W-1:0] remain;
  phase_e            upcoming;
  logic [TIME_W-1:0] upcoming_load;

  assign phase_end = (phase != PH_IDLE) && (remain == '0);
  assign upcoming  = phase_after(phase);

  always_comb begin
    unique case (upcoming)
      PH_CSS:  upcoming_load = wr_setup_q;
      PH_ACT:  upcoming_load = wr_active_q;
      PH_HOLD: upcoming_load = wr_hold_q;
      default: upcoming_load = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      remain <= '0;
    end else if (take) begin
      phase  <= PH_ADDR;
      remain <= cs_setup_now;
    end else if (phase_end) begin
      phase  <= upcoming;
      remain <= upcoming_load;
    end else if (phase != PH_IDLE) begin
      remain <= remain - 1'b1;
    end
  end

endmodule

// File: rtl/lcd_wr_seq.sv
module lcd_wr_seq
  import lcd_wr_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned TIME_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_rs,
  input  logic [DATA_W-1:0] req_data,
  input  logic [TIME_W-1:0] t_cs_setup,
  input  logic [TIME_W-1:0] t_wr_setup,
  input  logic [TIME_W-1:0] t_wr_active,
  input  logic [TIME_W-1:0] t_wr_hold,
  output logic              lcd_rs,
  output logic              lcd_cs_n,
  output logic              lcd_wr_n,
  output logic [DATA_W-1:0] lcd_data,
  output logic              busy
);

  localparam int unsigned LEN_W = TIME_W + 1;

  phase_e            phase;
  logic              phase_end;
  logic              take;
  logic [TIME_W-1:0] cs_setup_q, wr_setup_q, wr_active_q, wr_hold_q;

  assign req_ready = (phase == PH_IDLE);
  assign take      = req_valid && req_ready;
  assign busy      = (phase != PH_IDLE);
  assign lcd_cs_n  = !sel_low(phase);
  assign lcd_wr_n  = !strobe_low(phase);

  lcd_wr_capture #(.DATA_W(DATA_W), .TIME_W(TIME_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .take(take),
    .rs_in(req_rs), .data_in(req_data),
    .cs_setup_in(t_cs_setup), .wr_setup_in(t_wr_setup),
    .wr_active_in(t_wr_active), .wr_hold_in(t_wr_hold),
    .rs_q(lcd_rs), .data_q(lcd_data),
    .cs_setup_q(cs_setup_q), .wr_setup_q(wr_setup_q),
    .wr_active_q(wr_active_q), .wr_hold_q(wr_hold_q)
  );

  lcd_wr_phase_ctl #(.TIME_W(TIME_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .take(take),
    .cs_setup_now(t_cs_setup),
    .wr_setup_q(wr_setup_q), .wr_active_q(wr_active_q), .wr_hold_q(wr_hold_q),
    .phase(phase), .phase_end(phase_end)
  );

  // strobe-low length observer for the checks below
  logic [LEN_W-1:0] strobe_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         strobe_len <= '0;
    else if (!lcd_wr_n) strobe_len <= strobe_len + 1'b1;
    else                strobe_len <= '0;
  end

  AST_STROBE_INSIDE_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    !lcd_wr_n |-> !lcd_cs_n); // R9
  AST_BUS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(lcd_data) && $stable(lcd_rs))); // R8
  AST_SEL_AFTER_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lcd_cs_n) |-> $past(busy)); // R2
  AST_STROBE_AFTER_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lcd_wr_n) |-> $past(!lcd_cs_n)); // R3
  AST_STROBE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lcd_wr_n) |-> (strobe_len == LEN_W'(phase_clocks(32'(wr_active_q))))); // R4
  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready); // R7

endmodule

// File: tb/sim_lcd_wr_seq.sv
`timescale 1ns/1ps
module sim_lcd_wr_seq;

  localparam int DW = 8;
  localparam int TW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_rs = 1'b0;
  logic [DW-1:0] req_data = '0;
  logic [TW-1:0] t_cs_setup = 4'd0, t_wr_setup = 4'd0, t_wr_active = 4'd1, t_wr_hold = 4'd0;
  logic req_ready, lcd_rs, lcd_cs_n, lcd_wr_n, busy;
  logic [DW-1:0] lcd_data;

  int checks = 0;
  int failures = 0;
  bit model_on = 1'b0;
  string scen = "base";

  typedef struct packed { logic cs_n; logic wr_n; } pins_t;
  pins_t exp_q[$];
  logic exp_rs = 1'b0;
  logic [DW-1:0] exp_data = '0;

  always #2.5 clk = ~clk;

  lcd_wr_seq #(.DATA_W(DW), .TIME_W(TW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_rs(req_rs), .req_data(req_data),
    .t_cs_setup(t_cs_setup), .t_wr_setup(t_wr_setup),
    .t_wr_active(t_wr_active), .t_wr_hold(t_wr_hold),
    .lcd_rs(lcd_rs), .lcd_cs_n(lcd_cs_n), .lcd_wr_n(lcd_wr_n),
    .lcd_data(lcd_data), .busy(busy)
  );

  task automatic check(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s [%s] actual=%0d expected=%0d at %0t", what, scen, act, exp, $time);
    end
  endtask

  // behavioural reference: each accepted request expands into per-clock pin values
  always @(negedge clk) if (model_on) begin
    pins_t e;
    bit eb;
    eb = (exp_q.size() > 0);
    if (eb) e = exp_q.pop_front();
    else    e = '{cs_n: 1'b1, wr_n: 1'b1};
    check("cs_n R2 R3 R5 R6", int'(lcd_cs_n), int'(e.cs_n));
    check("wr_n R3 R4 R6 R9", int'(lcd_wr_n), int'(e.wr_n));
    check("ready R7", int'(req_ready), int'(!eb));
    check("busy R7", int'(busy), int'(eb));
    if (eb) begin
      check("rs R8", int'(lcd_rs), int'(exp_rs));
      check("data R8", int'(lcd_data), int'(exp_data));
    end
    if (!eb && req_valid) begin
      exp_rs = req_rs;
      exp_data = req_data;
      for (int i = 0; i <= int'(t_cs_setup); i++)  exp_q.push_back('{cs_n: 1'b1, wr_n: 1'b1});
      for (int i = 0; i <= int'(t_wr_setup); i++)  exp_q.push_back('{cs_n: 1'b0, wr_n: 1'b1});
      for (int i = 0; i <= int'(t_wr_active); i++) exp_q.push_back('{cs_n: 1'b0, wr_n: 1'b0});
      for (int i = 0; i <= int'(t_wr_hold); i++)   exp_q.push_back('{cs_n: 1'b0, wr_n: 1'b1});
    end
  end

  task automatic send(input logic rs, input logic [DW-1:0] d,
                      input int cs, input int ws, input int wa, input int wh);
    @(posedge clk); #1;
    req_valid = 1'b1; req_rs = rs; req_data = d;
    t_cs_setup = TW'(cs); t_wr_setup = TW'(ws); t_wr_active = TW'(wa); t_wr_hold = TW'(wh);
    do @(negedge clk); while (!req_ready);
    @(posedge clk); #1;
    req_valid = 1'b0;
    req_data = ~d; req_rs = ~rs;   // bus must not follow the inputs (R8)
  endtask

  task automatic drain();
    while (busy || exp_q.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("reset cs_n R1", int'(lcd_cs_n), 1);
    check("reset wr_n R1", int'(lcd_wr_n), 1);
    check("reset busy R1", int'(busy), 0);
    check("reset ready R1", int'(req_ready), 1);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    model_on = 1'b1;

    scen = "defaults";
    send(1'b0, 8'h2C, 0, 0, 1, 0); drain();
    scen = "all zero";
    send(1'b1, 8'hA5, 0, 0, 0, 0); drain();
    scen = "all max";
    send(1'b1, 8'h5A, 15, 15, 15, 15); drain();
    scen = "mixed";
    send(1'b0, 8'h3C, 2, 5, 3, 7); drain();
    send(1'b1, 8'hC3, 7, 1, 0, 4); drain();

    scen = "back to back R7";
    send(1'b0, 8'h11, 1, 0, 2, 1);
    send(1'b1, 8'h22, 0, 0, 0, 0);
    send(1'b1, 8'h33, 3, 2, 1, 0);
    drain();

    // R6: counts change while a transfer runs
    scen = "midway change R6";
    send(1'b1, 8'h77, 3, 3, 3, 3);
    repeat (2) @(posedge clk);
    #1 t_cs_setup = 4'd12; t_wr_setup = 4'd9; t_wr_active = 4'd0; t_wr_hold = 4'd14;
    drain();

    check("final idle cs_n R5", int'(lcd_cs_n), 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(5ns * 20000);
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule